// File: doc/BRIEF.md
# Two-Wire Serial Control Register Slave

This block is a two-wire serial slave that owns a bank of 128 byte-wide control registers. The serial clock and data come in on two input pins and are oversampled by the system clock through a synchroniser. The slave answers on a separate output pin. That pin carries the acknowledge and the read data, and the read data leaves it inverted. The block detects bus start and stop conditions and recognises one device address for writes (24h) and one for reads (25h).

A write transfer works as follows. The master sends the write address, then a register index, then any number of data bytes. Each data byte lands at the current index, and the index then steps by one, wrapping from 7Fh to 00h. For a read, the master first sets the index with a write-address sequence, then issues a new start and the read address. The slave then shifts register contents out on its answer pin. It keeps going while the master acknowledges each byte. The whole register bank is presented as one flat vector so that the surrounding logic can use it.

Top module: `csr_ser_slave`

## Requirements
- R1: While `rst_n` is low, every register byte reads 00h on `reg_image_o` and `resp_o` is low.
- R2: A falling `ser_dat_i` while `ser_clk_i` is high is a start. A rising `ser_dat_i` while `ser_clk_i` is high is a stop. Either one drives `resp_o` low at once, including in the middle of an acknowledge.
- R3: Bytes are received MSB first. When the device address byte is 24h or 25h, `resp_o` is high from the falling edge of the 8th clock until the falling edge of the 9th clock, and low after that in a write.
- R4: Any other device address gets no acknowledge (`resp_o` stays low). Every later byte is ignored, and no register changes, until the next start.
- R5: In a write, the first byte after address 24h is acknowledged, and its low 7 bits become the register index.
- R6: Each further byte in a write is stored at the current index and acknowledged, and the index then increments by one. The number of bytes in a transfer is not limited.
- R7: The register index wraps from 7Fh to 00h, both when writing and when reading.
- R8: After address 25h, the byte at the current index is driven on `resp_o` inverted, MSB first. Each bit is updated on a falling clock edge (bit 7 on the falling edge of the address's 9th clock). `resp_o` is low during the 9th clock of each read byte.
- R9: During a read, `ser_dat_i` low at the 9th rising edge makes the slave continue with the next index. `ser_dat_i` high there ends the read: `resp_o` stays low through any further clocks until the next start.
- R10: A byte cut short by a stop is discarded. An extra dummy clock after the last acknowledge, followed by a stop, changes no register.
- R11: Reading never changes any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the master, asynchronous |
| ser_dat_i | input | 1 | Serial data from the master, asynchronous |
| resp_o | output | 1 | Acknowledge and inverted read data to the master |
| reg_image_o | output | 1024 | All 128 register bytes, byte n at bits [8n+7:8n] |

## Verification
The bench targets the index wrap at 7Fh, in both writes and a three-byte read that crosses it. A design that saturates or carries into an eighth bit would store or return the wrong byte there. It also checks acknowledge timing on both sides of the 9th clock, and sends a foreign device address followed by data. A slave that does not fall silent would acknowledge or write in that case. Partial bytes, dummy clocks and a stop during an acknowledge are applied to catch a design that commits half-received bytes or holds the answer pin high. Master not-acknowledge is followed by extra clocks to expose a read that keeps shifting.

// File: rtl/csr_ser_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and protocol phase encoding for the serial
// control register slave.
package csr_ser_pkg;

    // Width of one serial byte; fixed by the protocol.
    localparam int BYTE_W = 8;

    // Protocol phase of the slave sequencer.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // bus free, waiting for start
        PH_DEV  = 3'd1,   // receiving the device address byte
        PH_PTR  = 3'd2,   // receiving the register index byte
        PH_WR   = 3'd3,   // receiving data bytes to store
        PH_RD   = 3'd4,   // sending register bytes
        PH_SKIP = 3'd5    // not addressed or read ended, wait for start
    } phase_t;

endpackage

// File: rtl/csr_ser_sync.sv
`timescale 1ns/1ps
// Module: csr_ser_sync
// Brings asynchronous serial lines into the system clock domain through a
// chain of STAGES flops per line and reports the synchronised level plus
// single-cycle rise and fall pulses.
// Assumes: lines idle high, so the chain resets to ones.
module csr_ser_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;

        // Shift the raw line through the synchroniser and one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-1:0], lines_i[g]};
            end
        end

        assign level_o[g] = chain[STAGES-1];
        assign rise_o[g]  = chain[STAGES-1] & ~chain[STAGES];
        assign fall_o[g]  = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/csr_ser_cond.sv
`timescale 1ns/1ps
// Module: csr_ser_cond
// Classifies synchronised line events into bus start, bus stop and
// ordinary clock edges.
// Assumes: inputs are single-cycle pulses from csr_ser_sync.
module csr_ser_cond (
    input  logic scl_lvl_i,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o,
    output logic bit_rise_o,
    output logic bit_fall_o
);

    // Data moving while the clock is high marks a bus condition.
    always_comb begin
        start_o    = sda_fall_i & scl_lvl_i;
        stop_o     = sda_rise_i & scl_lvl_i;
        bit_rise_o = scl_rise_i & ~(start_o | stop_o);
        bit_fall_o = scl_fall_i & ~(start_o | stop_o);
    end

endmodule

// File: rtl/csr_ser_proto.sv
`timescale 1ns/1ps
// Module: csr_ser_proto
// Byte sequencer of the serial slave: counts bits, matches the device
// address, loads the register index, issues writes, shifts read bytes out
// inverted and drives the answer line on falling clock edges.
// Assumes: start/stop/edge inputs are exclusive single-cycle pulses.
module csr_ser_proto
    import csr_ser_pkg::*;
#(
    parameter int               ADDR_W = 7,
    parameter logic [BYTE_W-2:0] DEV_ID = 7'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              data_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              resp_o
);

    localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
    localparam logic [3:0]        LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0]        ACK_SLOT = 4'(BYTE_W);

    phase_t              phase;
    phase_t              after_ack;
    logic [3:0]          cnt;
    logic [BYTE_W-2:0]   shreg;
    logic                ack_pend;
    logic [BYTE_W-1:0]   byte_full;

    // Byte as it stands once the bit on the current rising edge is added.
    always_comb begin
        byte_full = {shreg, data_i};
    end

    // Sequencer: bit counting, byte decode, index and answer line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            after_ack <= PH_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            ack_pend  <= 1'b0;
            ptr_o     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            resp_o    <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_i) begin
                phase    <= PH_DEV;
                cnt      <= '0;
                ack_pend <= 1'b0;
                resp_o   <= 1'b0;
            end else if (stop_i) begin
                phase    <= PH_IDLE;
                cnt      <= '0;
                ack_pend <= 1'b0;
                resp_o   <= 1'b0;
            end else if (phase != PH_IDLE && phase != PH_SKIP) begin
                if (rise_i) begin
                    if (cnt != ACK_SLOT) begin
                        shreg <= byte_full[BYTE_W-2:0];
                        cnt   <= cnt + 4'd1;
                        if (cnt == LAST_BIT) begin
                            case (phase)
                                PH_DEV: begin
                                    if (byte_full[BYTE_W-1:1] == DEV_ID) begin
                                        ack_pend  <= 1'b1;
                                        after_ack <= byte_full[0] ? PH_RD : PH_PTR;
                                    end else begin
                                        ack_pend  <= 1'b0;
                                        after_ack <= PH_SKIP;
                                    end
                                end
                                PH_PTR: begin
                                    ptr_o     <= byte_full[ADDR_W-1:0];
                                    ack_pend  <= 1'b1;
                                    after_ack <= PH_WR;
                                end
                                PH_WR: begin
                                    wr_en_o   <= 1'b1;
                                    wr_addr_o <= ptr_o;
                                    wr_data_o <= byte_full;
                                    ptr_o     <= ptr_o + PTR_ONE;
                                    ack_pend  <= 1'b1;
                                    after_ack <= PH_WR;
                                end
                                default: begin
                                    ack_pend  <= 1'b0;
                                    after_ack <= PH_RD;
                                end
                            endcase
                        end
                    end else begin
                        cnt      <= '0;
                        ack_pend <= 1'b0;
                        if (phase == PH_RD) begin
                            ptr_o <= ptr_o + PTR_ONE;
                            phase <= data_i ? PH_SKIP : PH_RD;
                        end else begin
                            phase <= after_ack;
                        end
                    end
                end else if (fall_i) begin
                    if (cnt == ACK_SLOT) begin
                        resp_o <= ack_pend;
                    end else if (phase == PH_RD) begin
                        resp_o <= ~rd_byte_i[~cnt[2:0]];
                    end else begin
                        resp_o <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/csr_ser_regbank.sv
`timescale 1ns/1ps
// Module: csr_ser_regbank
// Byte register bank held as one flat vector, one write port and one
// combinational read port.
// Assumes: one write per cycle at most.
module csr_ser_regbank
    import csr_ser_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [BYTE_W-1:0]              wr_data_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    output logic [BYTE_W-1:0]              rd_data_o,
    output logic [(1<<ADDR_W)*BYTE_W-1:0]  image_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH*BYTE_W-1:0] store;

    // Store one byte per write pulse; clear all bytes on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en_i) begin
            store[int'(wr_addr_i)*BYTE_W +: BYTE_W] <= wr_data_i;
        end
    end

    // Read mux and flat export.
    always_comb begin
        rd_data_o = store[int'(rd_addr_i)*BYTE_W +: BYTE_W];
        image_o   = store;
    end

endmodule

// File: rtl/csr_ser_slave.sv
`timescale 1ns/1ps
// Module: csr_ser_slave
// Top of the serial control register slave: synchroniser, bus condition
// classifier, byte sequencer and register bank.
// Assumes: the master changes data only while the serial clock is low and
// holds each clock phase for several system clock cycles.
module csr_ser_slave
    import csr_ser_pkg::*;
#(
    parameter int               ADDR_W      = 7,
    parameter int               SYNC_STAGES = 2,
    parameter logic [BYTE_W-2:0] DEV_ID     = 7'h12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk_i,
    input  logic                          ser_dat_i,
    output logic                          resp_o,
    output logic [(1<<ADDR_W)*BYTE_W-1:0] reg_image_o
);

    logic [1:0]        lvl, rse, fll;
    logic              evt_start, evt_stop, evt_rise, evt_fall;
    logic [ADDR_W-1:0] cur_ptr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_byte;

    csr_ser_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({ser_dat_i, ser_clk_i}),
        .level_o (lvl),
        .rise_o  (rse),
        .fall_o  (fll)
    );

    csr_ser_cond u_cond (
        .scl_lvl_i  (lvl[0]),
        .scl_rise_i (rse[0]),
        .scl_fall_i (fll[0]),
        .sda_rise_i (rse[1]),
        .sda_fall_i (fll[1]),
        .start_o    (evt_start),
        .stop_o     (evt_stop),
        .bit_rise_o (evt_rise),
        .bit_fall_o (evt_fall)
    );

    csr_ser_proto #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (evt_start),
        .stop_i    (evt_stop),
        .rise_i    (evt_rise),
        .fall_i    (evt_fall),
        .data_i    (lvl[1]),
        .rd_byte_i (rd_byte),
        .ptr_o     (cur_ptr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .resp_o    (resp_o)
    );

    csr_ser_regbank #(.ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (cur_ptr),
        .rd_data_o (rd_byte),
        .image_o   (reg_image_o)
    );

endmodule

// File: rtl/csr_ser_slave_chk.sv
`timescale 1ns/1ps
// Module: csr_ser_slave_chk
// Property checker bound to csr_ser_slave; watches the hand-off between
// condition detector, sequencer and register bank.
module csr_ser_slave_chk
    import csr_ser_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          stop_i,
    input  logic                          fall_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [BYTE_W-1:0]             wr_data_i,
    input  logic [ADDR_W-1:0]             ptr_i,
    input  logic                          resp_i,
    input  logic [(1<<ADDR_W)*BYTE_W-1:0] image_i
);

    // Reset clears the answer line and the bank (R1).
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!resp_i && image_i == '0));

    // A bus condition releases the answer line (R2).
    p_cond_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> !resp_i);

    // The answer line only moves after a falling clock or a bus condition (R8).
    p_resp_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_i != $past(resp_i)) |-> ($past(fall_i) || $past(start_i) || $past(stop_i)));

    // A stored byte lands at the written index (R6).
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (image_i[int'($past(wr_addr_i))*BYTE_W +: BYTE_W] == $past(wr_data_i)));

    // The index moves one past the written entry, wrapping at the top (R7).
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (ptr_i == ADDR_W'(wr_addr_i + ADDR_W'(1))));

    // Without a write pulse the bank holds still (R11).
    p_image_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(image_i));

endmodule

bind csr_ser_slave csr_ser_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (evt_start),
    .stop_i    (evt_stop),
    .fall_i    (evt_fall),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .ptr_i     (cur_ptr),
    .resp_i    (resp_o),
    .image_i   (reg_image_o)
);

// File: tb/csr_ser_slave_test.sv
`timescale 1ns/1ps
// Bench for csr_ser_slave: directed corner cases plus seeded random bursts.
module csr_ser_slave_test;

    localparam int H = 6;   // system cycles per serial half phase

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda = 1'b1;
    logic          resp;
    logic [1023:0] img;
    logic [7:0]    model [128];
    int            n_chk = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    csr_ser_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (scl),
        .ser_dat_i   (sda),
        .resp_o      (resp),
        .reg_image_o (img)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected level on the answer line for a read bit.
    function automatic logic exp_level(input logic [7:0] v, input int pos);
        return ~v[pos];
    endfunction

    function automatic int wrap_idx(input int a);
        return a % 128;
    endfunction

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; half();
        scl = 1'b1; half();
        sda = 1'b0; half();
        scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda = 1'b0; half();
        scl = 1'b1; half();
        sda = 1'b1; half();
    endtask

    task automatic clock_bit(input logic b);
        sda = b;    half();
        scl = 1'b1; half();
        scl = 1'b0; half();
    endtask

    // Eight bits MSB first, then the ninth clock with the slave answer checked.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        chk(32'(resp), 32'(exp_ack), tag);
        sda = 1'b1; half();
        scl = 1'b1; half();
        chk(32'(resp), 32'(exp_ack), tag);
        scl = 1'b0; half();
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            sda = 1'b1; half();
            got[i] = ~resp;
            scl = 1'b1; half();
            scl = 1'b0; half();
        end
        chk(32'(resp), 32'd0, "R8 ninth clock of read byte low");
        sda = nack; half();
        scl = 1'b1; half();
        scl = 1'b0; half();
    endtask

    task automatic chk_image(input string tag);
        int bad = 0;
        for (int a = 0; a < 128; a++) if (img[a*8 +: 8] !== model[a]) bad++;
        chk(32'(bad), 32'd0, tag);
    endtask

    task automatic write_burst(input int p, input int n, input logic [7:0] d [8]);
        bus_start();
        send_byte(8'h24, 1'b1, "R3 write address ack");
        chk(32'(resp), 32'd0, "R3 ack released after ninth clock");
        send_byte(8'(p), 1'b1, "R5 index byte ack");
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, "R6 data byte ack");
            model[wrap_idx(p + k)] = d[k];
        end
        bus_stop();
    endtask

    task automatic set_index(input int p);
        bus_start();
        send_byte(8'h24, 1'b1, "R5 write address ack");
        send_byte(8'(p), 1'b1, "R5 index byte ack");
        bus_stop();
    endtask

    task automatic read_burst(input int p, input int n);
        logic [7:0] got;
        set_index(p);
        bus_start();
        send_byte(8'h25, 1'b1, "R3 read address ack");
        chk(32'(resp), 32'(exp_level(model[wrap_idx(p)], 7)), "R8 bit7 after address");
        for (int k = 0; k < n; k++) begin
            read_byte(k == n - 1, got);
            chk(32'(got), 32'(model[wrap_idx(p + k)]), "R8 R9 read byte");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d [8];
        void'($urandom(32'h5eed));
        for (int a = 0; a < 128; a++) model[a] = 8'h00;
        for (int k = 0; k < 8; k++) d[k] = 8'h00;

        // R1: reset state
        repeat (10) @(negedge clk);
        chk(32'(resp), 32'd0, "R1 answer low in reset");
        chk_image("R1 bank cleared");
        rst_n = 1'b1;
        half();

        // R5 R6: plain burst
        d[0] = 8'hAA; d[1] = 8'h55;
        write_burst(5, 2, d);
        chk_image("R6 burst stored");

        // R7: write across the top index
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        write_burst(8'h7E, 3, d);
        chk_image("R7 write wraps");

        // R4: foreign device address
        bus_start();
        send_byte(8'h30, 1'b0, "R4 no ack for foreign address");
        send_byte(8'h01, 1'b0, "R4 ignored byte");
        send_byte(8'hFF, 1'b0, "R4 ignored byte");
        bus_stop();
        chk_image("R4 bank untouched");

        // R7 R8 R9: read across the top index, then clocks after not-acknowledge
        read_burst(8'h7E, 3);
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1);
            chk(32'(resp), 32'd0, "R9 silent after master not-acknowledge");
        end
        bus_stop();
        chk_image("R11 read leaves bank unchanged");

        // R10: stop inside a byte
        bus_start();
        send_byte(8'h24, 1'b1, "R5 write address ack");
        send_byte(8'h10, 1'b1, "R5 index byte ack");
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        bus_stop();
        chk_image("R10 partial byte discarded");

        // R10: dummy clock after the last acknowledge
        bus_start();
        send_byte(8'h24, 1'b1, "R5 write address ack");
        send_byte(8'h20, 1'b1, "R5 index byte ack");
        send_byte(8'h5A, 1'b1, "R6 data byte ack");
        model[8'h20] = 8'h5A;
        clock_bit(1'b1);
        bus_stop();
        chk_image("R10 dummy clock harmless");

        // R2: stop during an acknowledge releases the answer line
        bus_start();
        send_byte(8'h24, 1'b1, "R5 write address ack");
        for (int i = 7; i >= 0; i--) clock_bit(1'b0);
        chk(32'(resp), 32'd1, "R3 ack after eighth bit");
        sda = 1'b0; half();
        scl = 1'b1; half();
        chk(32'(resp), 32'd1, "R2 ack held before stop");
        sda = 1'b1; half();
        chk(32'(resp), 32'd0, "R2 stop releases answer");
        chk_image("R2 bank unchanged");

        // Random bursts with read-back
        for (int it = 0; it < 12; it++) begin
            int p = int'($urandom % 128);
            int n = 1 + int'($urandom % 5);
            for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
            write_burst(p, n, d);
            chk_image("R6 R7 random burst");
            read_burst(p, n);
            bus_stop();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule